// File: doc/BRIEF.md
# Indexed Register Port with Voice Interrupt Collection

This block is the host-facing control front end of a multi-voice sample player. A byte-wide host bus picks one of four ports with a two-bit select. One port holds an 8-bit register index. Two data ports then read or write the low and high byte of the 16-bit register that the index names. A fourth port is a read-only status summary. Per-voice registers are reached indirectly: a global register holds a voice pointer, and every per-voice access goes to the voice it points at. The block also holds the per-voice running and finished flags and issues key-on commands to the voice engines.

The voice engines and the interval timers are outside the block. A voice engine reports the end of its sample with a one-cycle pulse on its done-set input. A timer reports expiry with a one-cycle pulse. The block gathers the finished voices and the enabled timer events into one registered interrupt line. Some reads have side effects. Reading the interrupt-source register hands back the lowest-numbered finished voice and acknowledges it. Reading a timer register acknowledges that timer's pending bit. The host can therefore service interrupts with nothing but register reads.

Top module: `sndctl_regport`

## Requirements
- R1: A write to port 1 (select 2'b01) loads the register index, and a read of port 1 returns it. Select 2'b10 is the low-byte data port and select 2'b11 is the high-byte data port. A read of either returns that byte of the indexed register's value.
- R2: A low-byte write to index 0x4F sets the voice pointer to the data masked to the voice count minus one. Index 0x00 (high byte only; its low byte reads 0x00) and index 0x01 (both bytes) are per-voice registers. They are written and read in the pointed voice only.
- R3: A high-byte write of 0x00 to index 0x10 sets the pointed voice's active flag on the next clock. A nonzero value, or a low-byte write, leaves the active flags unchanged.
- R4: A done-set pulse for a voice clears its active flag and sets its done flag. If a key-on for the same voice arrives in the same cycle, the done-set wins.
- R5: The interrupt output is registered. One clock after the state changes, it is high exactly when some timer is both pending and enabled, or some voice is done.
- R6: While voices are done, a read of index 0x0F returns 0x40 OR the lowest done voice number in the high byte and 0x00 in the low byte. The read clears that voice's done flag at the clock edge. This holds for reads on either data port. With no voice done, the high byte reads 0xFF and nothing changes. A done-set arriving in the same cycle as the clear keeps the flag set.
- R7: A data-port read of index 0x40 clears timer pending bit 0, and a read of 0x41 clears bit 1. The low byte of each returns the preset value last written to that index's low byte. Writing a preset does not touch the pending bits.
- R8: A timer expiry pulse sets its pending bit at that clock edge. An expiry that coincides with a clearing read leaves the bit set.
- R9: Index 0x43 reads the pending bits ANDed with 3 in the low byte. A low-byte write of index 0x4A loads the timer enable mask, and a read of index 0x4A returns the pending bits. Index 0x4C reads 0x01 in the low byte. Any other index reads 0x0000.
- R10: Port 0 (select 2'b00) reads 0x00 while the interrupt output is low. Otherwise bit 7 is set, bit 0 shows an enabled pending timer, and bit 1 shows any done voice.
- R11: A pending timer whose enable bit is clear does not raise the interrupt output.
- R12: Reset clears the index, the voice pointer, the enables, the pending bits, the presets, and every voice's registers and flags. The interrupt output reads low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Port select: 0 status, 1 index, 2 low data, 3 high data |
| host_wr | input | 1 | Write strobe, sampled at the clock edge |
| host_rd | input | 1 | Read strobe; read side effects apply at the clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected port (combinational) |
| voice_done_set | input | NUM_VOICES | Per-voice end-of-sample pulses from the voice engines |
| timer_expire | input | NUM_TIMERS | Per-timer expiry pulses |
| voice_active | output | NUM_VOICES | Per-voice running flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. One is a source read that pops a voice while that voice's engine reports done again. Another is a timer-clearing read that lands in the same cycle as a fresh expiry. A third is a key-on that meets a done-set for the same voice. The bench reaches each one by raising the engine or timer pulse before it issues the host read or write inside the same task. All of them then share one clock edge. Afterwards the bench reads the affected state back through the source and status registers. It also times the one-cycle lag of the interrupt line by sampling on each side of the update.

// File: rtl/sndctl_pkg.sv
package sndctl_pkg;

   typedef enum logic [1:0] {
      PORT_STATUS = 2'd0,
      PORT_INDEX  = 2'd1,
      PORT_LO     = 2'd2,
      PORT_HI     = 2'd3
   } port_t;

   localparam logic [7:0] IDX_VCFG  = 8'h00;
   localparam logic [7:0] IDX_VRATE = 8'h01;
   localparam logic [7:0] IDX_SRC   = 8'h0F;
   localparam logic [7:0] IDX_KEY   = 8'h10;
   localparam logic [7:0] IDX_TMR0  = 8'h40;
   localparam logic [7:0] IDX_TSTAT = 8'h43;
   localparam logic [7:0] IDX_IEN   = 8'h4A;
   localparam logic [7:0] IDX_REV   = 8'h4C;
   localparam logic [7:0] IDX_VPTR  = 8'h4F;

   localparam logic [7:0] SRC_TAG   = 8'h40;
   localparam logic [7:0] SRC_EMPTY = 8'hFF;
   localparam logic [7:0] KEY_CODE  = 8'h00;

   localparam logic       STAT_IRQ_BIT = 1'b1;

endpackage

// File: rtl/sndctl_lowest_pick.sv
module sndctl_lowest_pick #(
   parameter int N  = 32,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/sndctl_voice_bank.sv
module sndctl_voice_bank #(
   parameter int NUM_VOICES = 32,
   parameter int PW         = $clog2(NUM_VOICES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PW-1:0]         vptr,
   input  logic [7:0]            wdata,
   input  logic                  cfg_we,
   input  logic                  rate_we_lo,
   input  logic                  rate_we_hi,
   input  logic                  key_on,
   input  logic [NUM_VOICES-1:0] done_set,
   input  logic                  pop_en,
   input  logic [PW-1:0]         pop_idx,
   output logic [7:0]            cfg_rd,
   output logic [15:0]           rate_rd,
   output logic [NUM_VOICES-1:0] active,
   output logic [NUM_VOICES-1:0] done
);

   logic [7:0]  cfg_mem  [NUM_VOICES];
   logic [15:0] rate_mem [NUM_VOICES];

   for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
      logic hit;
      logic popped;
      assign hit    = (vptr == PW'(v));
      assign popped = pop_en && (pop_idx == PW'(v));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_mem[v]  <= '0;
            rate_mem[v] <= '0;
            active[v]   <= 1'b0;
            done[v]     <= 1'b0;
         end else begin
            if (hit && cfg_we)     cfg_mem[v]        <= wdata;
            if (hit && rate_we_lo) rate_mem[v][7:0]  <= wdata;
            if (hit && rate_we_hi) rate_mem[v][15:8] <= wdata;

            if (done_set[v])         active[v] <= 1'b0;
            else if (hit && key_on)  active[v] <= 1'b1;

            if (done_set[v])         done[v] <= 1'b1;
            else if (popped)         done[v] <= 1'b0;
         end
      end

      // R4
      done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_set[v] |=> (done[v] && !active[v]))
         else $error("done-set did not finish voice %0d", v);

      // R3
      keyon_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (key_on && hit && !done_set[v]) |=> active[v])
         else $error("key-on lost on voice %0d", v);

      // R6
      pop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (popped && !done_set[v]) |=> !done[v])
         else $error("pop did not clear voice %0d", v);
   end

   assign cfg_rd  = cfg_mem[vptr];
   assign rate_rd = rate_mem[vptr];

endmodule

// File: rtl/sndctl_irq_ctrl.sv
module sndctl_irq_ctrl #(
   parameter int NUM_TIMERS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ien_we,
   input  logic [NUM_TIMERS-1:0] ien_wdata,
   input  logic [NUM_TIMERS-1:0] tmr_expire,
   input  logic [NUM_TIMERS-1:0] tmr_clr,
   input  logic                  voice_any,
   output logic [NUM_TIMERS-1:0] pend,
   output logic [NUM_TIMERS-1:0] ien,
   output logic                  tmr_irq,
   output logic                  irq_q
);

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      always_ff @(posedge clk) begin
         if (!rst_n)             pend[t] <= 1'b0;
         else if (tmr_expire[t]) pend[t] <= 1'b1;
         else if (tmr_clr[t])    pend[t] <= 1'b0;
      end

      // R8
      tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_expire[t] |=> pend[t])
         else $error("timer %0d expiry lost", t);

      // R7
      tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tmr_clr[t] && !tmr_expire[t]) |=> !pend[t])
         else $error("timer %0d clear lost", t);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ien <= '0;
      else if (ien_we) ien <= ien_wdata;
   end

   assign tmr_irq = |(ien & pend);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= tmr_irq || voice_any;
   end

   // R5
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_irq || voice_any) |=> irq_q)
      else $error("interrupt not raised");

   // R11
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_irq && !voice_any) |=> !irq_q)
      else $error("interrupt raised without cause");

endmodule

// File: rtl/sndctl_regport.sv
module sndctl_regport
   import sndctl_pkg::*;
#(
   parameter int         NUM_VOICES = 32,
   parameter int         NUM_TIMERS = 2,
   parameter logic [7:0] REVISION   = 8'h01,
   localparam int        PW         = $clog2(NUM_VOICES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            host_sel,
   input  logic                  host_wr,
   input  logic                  host_rd,
   input  logic [7:0]            host_wdata,
   output logic [7:0]            host_rdata,
   input  logic [NUM_VOICES-1:0] voice_done_set,
   input  logic [NUM_TIMERS-1:0] timer_expire,
   output logic [NUM_VOICES-1:0] voice_active,
   output logic                  irq
);

   initial begin : param_chk
      assert (NUM_VOICES >= 2 && NUM_VOICES <= 64 &&
              (NUM_VOICES & (NUM_VOICES - 1)) == 0)
         else $error("NUM_VOICES must be a power of two in 2..64");
      assert (NUM_TIMERS >= 1 && NUM_TIMERS <= 2)
         else $error("NUM_TIMERS must be 1 or 2");
   end

   port_t port;
   assign port = port_t'(host_sel);

   logic [7:0]    idx_q;
   logic [PW-1:0] vptr_q;
   logic [7:0]    preset_q [NUM_TIMERS];

   logic wr_idx, wr_lo, wr_hi, rd_data;
   assign wr_idx  = host_wr && (port == PORT_INDEX);
   assign wr_lo   = host_wr && (port == PORT_LO);
   assign wr_hi   = host_wr && (port == PORT_HI);
   assign rd_data = host_rd && ((port == PORT_LO) || (port == PORT_HI));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         vptr_q <= '0;
      end else begin
         if (wr_idx) idx_q <= host_wdata;
         if (wr_lo && idx_q == IDX_VPTR) vptr_q <= host_wdata[PW-1:0];
      end
   end

   // voice side
   logic [7:0]            cfg_rd;
   logic [15:0]           rate_rd;
   logic [NUM_VOICES-1:0] done;
   logic                  src_found;
   logic [PW-1:0]         src_idx;
   logic                  pop_en;
   logic                  key_on;

   assign key_on = wr_hi && (idx_q == IDX_KEY) && (host_wdata == KEY_CODE);
   assign pop_en = rd_data && (idx_q == IDX_SRC) && src_found;

   sndctl_lowest_pick #(.N(NUM_VOICES), .IW(PW)) u_pick (
      .req   (done),
      .found (src_found),
      .idx   (src_idx)
   );

   sndctl_voice_bank #(.NUM_VOICES(NUM_VOICES), .PW(PW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .vptr       (vptr_q),
      .wdata      (host_wdata),
      .cfg_we     (wr_hi && idx_q == IDX_VCFG),
      .rate_we_lo (wr_lo && idx_q == IDX_VRATE),
      .rate_we_hi (wr_hi && idx_q == IDX_VRATE),
      .key_on     (key_on),
      .done_set   (voice_done_set),
      .pop_en     (pop_en),
      .pop_idx    (src_idx),
      .cfg_rd     (cfg_rd),
      .rate_rd    (rate_rd),
      .active     (voice_active),
      .done       (done)
   );

   // timer side
   logic [NUM_TIMERS-1:0] tmr_clr;
   logic [NUM_TIMERS-1:0] pend;
   logic [NUM_TIMERS-1:0] ien;
   logic                  tmr_irq;
   logic                  voice_any;

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      localparam logic [7:0] TIDX = IDX_TMR0 + 8'(t);
      assign tmr_clr[t] = rd_data && (idx_q == TIDX);
      always_ff @(posedge clk) begin
         if (!rst_n)                      preset_q[t] <= '0;
         else if (wr_lo && idx_q == TIDX) preset_q[t] <= host_wdata;
      end
   end

   assign voice_any = |done;

   sndctl_irq_ctrl #(.NUM_TIMERS(NUM_TIMERS)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ien_we     (wr_lo && idx_q == IDX_IEN),
      .ien_wdata  (host_wdata[NUM_TIMERS-1:0]),
      .tmr_expire (timer_expire),
      .tmr_clr    (tmr_clr),
      .voice_any  (voice_any),
      .pend       (pend),
      .ien        (ien),
      .tmr_irq    (tmr_irq),
      .irq_q      (irq)
   );

   // readback
   logic [7:0]  pend_ext;
   logic [15:0] rd_word;
   logic [7:0]  status;

   assign pend_ext = 8'(pend);

   always_comb begin
      rd_word = 16'h0000;
      case (idx_q)
         IDX_VCFG:  rd_word = {cfg_rd, 8'h00};
         IDX_VRATE: rd_word = rate_rd;
         IDX_SRC:   rd_word = src_found ? {SRC_TAG | 8'(src_idx), 8'h00}
                                        : {SRC_EMPTY, 8'h00};
         IDX_TSTAT: rd_word = {8'h00, pend_ext & 8'h03};
         IDX_IEN:   rd_word = {8'h00, pend_ext};
         IDX_REV:   rd_word = {8'h00, REVISION};
         default: begin
            for (int t = 0; t < NUM_TIMERS; t++)
               if (idx_q == IDX_TMR0 + 8'(t)) rd_word = {8'h00, preset_q[t]};
         end
      endcase
   end

   assign status = irq ? {STAT_IRQ_BIT, 5'b00000, voice_any, tmr_irq} : 8'h00;

   always_comb begin
      case (port)
         PORT_STATUS: host_rdata = status;
         PORT_INDEX:  host_rdata = idx_q;
         PORT_LO:     host_rdata = rd_word[7:0];
         default:     host_rdata = rd_word[15:8];
      endcase
   end

   // R10
   status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && port == PORT_STATUS) |-> (host_rdata == 8'h00))
      else $error("status nonzero while interrupt idle");

   // R6
   src_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port == PORT_HI && idx_q == IDX_SRC && !voice_any) |-> (host_rdata == SRC_EMPTY))
      else $error("source read not empty with no done voice");

   // R12
   rst_quiet_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (!irq && voice_active == '0))
      else $error("state not cleared by reset");

endmodule

// File: tb/tb_sndctl_regport.sv
module tb_sndctl_regport;

   localparam int NV = 32;
   localparam int NT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    host_sel = 2'd0;
   logic          host_wr = 1'b0;
   logic          host_rd = 1'b0;
   logic [7:0]    host_wdata = 8'h00;
   logic [7:0]    host_rdata;
   logic [NV-1:0] voice_done_set = '0;
   logic [NT-1:0] timer_expire = '0;
   logic [NV-1:0] voice_active;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sndctl_regport #(.NUM_VOICES(NV), .NUM_TIMERS(NT)) dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .voice_done_set(voice_done_set), .timer_expire(timer_expire),
      .voice_active(voice_active), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic hw(input logic [1:0] p, input logic [7:0] d);
      host_sel = p; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hr(input logic [1:0] p, output logic [7:0] d);
      host_sel = p; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wreg(input logic [7:0] idx, input bit hi, input logic [7:0] d);
      hw(2'd1, idx);
      hw(hi ? 2'd3 : 2'd2, d);
   endtask

   task automatic rreg(input logic [7:0] idx, input bit hi, output logic [7:0] d);
      hw(2'd1, idx);
      hr(hi ? 2'd3 : 2'd2, d);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      chk("R12 irq after reset", irq, 0);
      chk("R12 active after reset", voice_active, 0);
      hr(2'd0, d); chk("R12 status after reset", d, 8'h00);
      hr(2'd1, d); chk("R12 index after reset", d, 8'h00);
      rreg(8'h0F, 1, d); chk("R6 empty source", d, 8'hFF);
   endtask

   task automatic t_index();
      logic [7:0] d;
      hw(2'd1, 8'h4C);
      hr(2'd1, d); chk("R1 index readback", d, 8'h4C);
      hr(2'd2, d); chk("R9 revision", d, 8'h01);
      hr(2'd3, d); chk("R1 revision high", d, 8'h00);
      rreg(8'h22, 0, d); chk("R9 undecoded low", d, 8'h00);
   endtask

   task automatic t_voice_regs();
      logic [7:0] d;
      wreg(8'h4F, 0, 8'h25);
      wreg(8'h01, 0, 8'h34); hw(2'd3, 8'h12);
      wreg(8'h00, 1, 8'h9C);
      wreg(8'h4F, 0, 8'h06);
      wreg(8'h01, 0, 8'hAB); hw(2'd3, 8'hCD);
      rreg(8'h00, 1, d); chk("R2 voice6 cfg untouched", d, 8'h00);
      wreg(8'h4F, 0, 8'h05);
      rreg(8'h01, 0, d); chk("R2 voice5 rate lo", d, 8'h34);
      hr(2'd3, d);       chk("R2 voice5 rate hi", d, 8'h12);
      rreg(8'h00, 1, d); chk("R2 voice5 cfg hi", d, 8'h9C);
      hr(2'd2, d);       chk("R2 cfg low reads zero", d, 8'h00);
   endtask

   task automatic t_keyon();
      wreg(8'h10, 1, 8'h07);
      chk("R3 nonzero key ignored", voice_active, 0);
      wreg(8'h10, 0, 8'h00);
      chk("R3 low-byte key ignored", voice_active, 0);
      hw(2'd3, 8'h00);
      chk("R3 key-on voice5", voice_active, 32'h0000_0020);
   endtask

   task automatic t_done();
      logic [7:0] d;
      voice_done_set = 32'h0000_0020;
      @(negedge clk);
      voice_done_set = '0;
      chk("R4 done clears active", voice_active, 0);
      chk("R5 irq lags one cycle", irq, 0);
      @(negedge clk);
      chk("R5 irq raised", irq, 1);
      hr(2'd0, d); chk("R10 status voice", d, 8'h82);
      voice_done_set = 32'h0000_0208;
      @(negedge clk);
      voice_done_set = '0;
      rreg(8'h0F, 1, d); chk("R6 pop lowest 3", d, 8'h43);
      hr(2'd3, d);       chk("R6 pop next 5", d, 8'h45);
      hr(2'd2, d);       chk("R6 low-port pop low byte", d, 8'h00);
      hr(2'd3, d);       chk("R6 empty after pops", d, 8'hFF);
      chk("R5 irq dropped", irq, 0);
      hr(2'd0, d); chk("R10 status idle", d, 8'h00);
   endtask

   task automatic t_timer();
      logic [7:0] d;
      wreg(8'h40, 0, 8'h5A);
      timer_expire = 2'b01;
      @(negedge clk);
      timer_expire = 2'b00;
      repeat (2) @(negedge clk);
      chk("R11 disabled timer no irq", irq, 0);
      rreg(8'h43, 0, d); chk("R9 timer status", d, 8'h01);
      rreg(8'h4A, 0, d); chk("R9 pending via 4A", d, 8'h01);
      wreg(8'h4A, 1, 8'h03);
      @(negedge clk);
      chk("R9 high write to enable ignored", irq, 0);
      hw(2'd2, 8'h01);
      @(negedge clk);
      chk("R5 enabled timer irq", irq, 1);
      hr(2'd0, d); chk("R10 status timer", d, 8'h81);
      rreg(8'h40, 0, d); chk("R7 preset readback", d, 8'h5A);
      @(negedge clk);
      chk("R7 clear drops irq", irq, 0);
      rreg(8'h43, 0, d); chk("R7 pending cleared", d, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      timer_expire = 2'b10;
      @(negedge clk);
      timer_expire = 2'b00;
      hw(2'd1, 8'h41);
      timer_expire = 2'b10;
      hr(2'd2, d);
      timer_expire = 2'b00;
      rreg(8'h43, 0, d); chk("R8 set wins over clear", d, 8'h02);
      rreg(8'h41, 0, d);
      rreg(8'h43, 0, d); chk("R7 timer1 cleared", d, 8'h00);
      voice_done_set = 32'h0000_0004;
      @(negedge clk);
      hw(2'd1, 8'h0F);
      voice_done_set = 32'h0000_0004;
      hr(2'd3, d);
      voice_done_set = '0;
      chk("R6 first pop 2", d, 8'h42);
      hr(2'd3, d); chk("R6 done-set beats pop", d, 8'h42);
      hr(2'd3, d); chk("R6 empty after collision", d, 8'hFF);
      wreg(8'h4F, 0, 8'h27);
      hw(2'd1, 8'h10);
      voice_done_set = 32'h0000_0080;
      hw(2'd3, 8'h00);
      voice_done_set = '0;
      chk("R4 done beats key-on", voice_active, 0);
      rreg(8'h0F, 1, d); chk("R4 collided voice done", d, 8'h47);
   endtask

   task automatic t_reset_again();
      logic [7:0] d;
      wreg(8'h4F, 0, 8'h05);
      wreg(8'h10, 1, 8'h00);
      voice_done_set = 32'h0000_0100;
      @(negedge clk);
      voice_done_set = '0;
      do_reset();
      chk("R12 active cleared", voice_active, 0);
      chk("R12 irq cleared", irq, 0);
      wreg(8'h4F, 0, 8'h05);
      rreg(8'h01, 0, d); chk("R12 voice rate cleared", d, 8'h00);
      rreg(8'h0F, 1, d); chk("R12 done cleared", d, 8'hFF);
      rreg(8'h40, 0, d); chk("R12 preset cleared", d, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_index();
      t_voice_regs();
      t_keyon();
      t_done();
      t_timer();
      t_collide();
      t_reset_again();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule